// File: doc/BRIEF.md
# Banked Interrupt Controller with Per-Source Trigger Mode and Polarity

This block collects interrupt requests from peripheral sources arranged in banks of 32 and presents one request line per bank to a processor. Each source can be level sensitive or edge sensitive, and each source picks its own active sense: high level or rising edge, or low level or falling edge. Raw source inputs are asynchronous to the controller clock, so each passes through a synchronizer before any level or edge logic sees it.

Software reaches the controller over a simple word-wide read/write register bus. Each bank has six registers: pending status, enable, set, clear, polarity and trigger mode. A source counts as requesting when it is both pending and enabled. The bank's line is the OR of those requests. Alongside the line, each bank gives the index of its lowest-numbered requesting source, with a valid flag, so that a handler can pick the source to serve first without scanning the status word.

Latched edge events stay pending until software clears them. Software can also make an edge-mode source pending on purpose. Level-mode status always shows the live, polarity-corrected input.

Top module: `irq_bank_ctrl`

## Requirements
- R1: Bank b occupies byte addresses b*0x18 to b*0x18+0x17. Within a bank, the offsets are: 0x00 pending status (read), 0x04 enable, 0x08 set (write 1 to set), 0x0C clear (write 1 to clear), 0x10 polarity, 0x14 trigger mode (1 = edge, 0 = level). Enable, polarity and trigger mode read back the value last written. Set and clear read as 0. A read at an address past the last bank returns 0. Read data appears on bus_rdata on the clock edge that samples bus_rd_en high, and it holds until the next read.
- R2: After reset, the enable, trigger-mode and status registers of every bank are 0, polarity is all ones, and all request, valid and index outputs are 0.
- R3: For a level-mode source, the status bit equals the input when polarity is 1 and the inverted input when polarity is 0. It follows the input with a latency of two synchronizer stages plus one register.
- R4: For an edge-mode source, a rising input edge (polarity 1) or a falling input edge (polarity 0) sets the status bit. The bit stays set after the input returns to its previous value. An edge of the other direction does not set it.
- R5: Writing 1s to the clear register removes the matching pending bits of edge-mode sources. When a clear and a new edge hit the same bit in the same cycle, the bit ends up set.
- R6: Writing 1s to the set register makes the matching edge-mode status bits pending. Set and clear writes leave level-mode status bits unchanged.
- R7: irq_out[b] is a registered copy of the OR over bank b of (status AND enable). No bank's line rises while its enable register is 0.
- R8: irq_idx for bank b gives the lowest bit position whose status and enable bits are both 1, and irq_vld[b] flags that such a bit exists. With no requesting source, both irq_vld[b] and the index are 0.
- R9: A register write to one bank changes no register and no output of any other bank.
- R10: After the bring-up sequence completes, no bank requests while the inputs are inactive, and a rising pulse on an edge-mode source is latched. The bring-up sequence is: all enables 0, all clear bits 1, all polarities 1, and bank 0 bits 13 to 15 set to edge mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | SRC_W | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rd_en | input | 1 | Read strobe; data is registered on this edge |
| bus_rdata | output | SRC_W | Registered read data |
| irq_src | input | NUM_BANKS*SRC_W | Raw source inputs, bank b at bits b*SRC_W upward |
| irq_out | output | NUM_BANKS | Per-bank request line toward the processor |
| irq_vld | output | NUM_BANKS | Per-bank flag that a requesting source exists |
| irq_idx | output | NUM_BANKS*$clog2(SRC_W) | Per-bank index of the lowest requesting source |

## Verification
The assertions assume a single bus agent that drives at most one access per cycle, with word-aligned addresses. They also assume reset is held high through the first clock edge. The edge-mode properties rely on each source level being held for at least the synchronizer depth plus one cycle, because a shorter pulse may never reach the edge detector. The bench changes inputs only between settling windows of six cycles. It issues writes and reads one at a time from the negative clock edge. Only one directed case places a clear write on the exact cycle that an edge is detected.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned BANK_STRIDE = 24;
  localparam int unsigned OFF_W       = 5;

  localparam logic [OFF_W-1:0] OFF_STAT = 5'h00;
  localparam logic [OFF_W-1:0] OFF_EN   = 5'h04;
  localparam logic [OFF_W-1:0] OFF_SET  = 5'h08;
  localparam logic [OFF_W-1:0] OFF_CLR  = 5'h0C;
  localparam logic [OFF_W-1:0] OFF_POL  = 5'h10;
  localparam logic [OFF_W-1:0] OFF_EDGE = 5'h14;

  function automatic logic off_legal(input logic [OFF_W-1:0] o);
    return (o == OFF_STAT) || (o == OFF_EN) || (o == OFF_SET) ||
           (o == OFF_CLR) || (o == OFF_POL) || (o == OFF_EDGE);
  endfunction
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
  import irqc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     src_sync,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [W-1:0]     wr_data,
  output logic [W-1:0]     stat_q,
  output logic [W-1:0]     en_q,
  output logic [W-1:0]     pol_q,
  output logic [W-1:0]     edg_q
);
  logic [W-1:0] prev_q;
  logic [W-1:0] rise, fall, hit, lvl;
  logic [W-1:0] set_m, clr_m, stat_nxt;

  always_comb begin
    rise     = src_sync & ~prev_q;
    fall     = ~src_sync & prev_q;
    hit      = ((rise & pol_q) | (fall & ~pol_q)) & edg_q;
    lvl      = ~(src_sync ^ pol_q);
    set_m    = (wr_en && wr_off == OFF_SET) ? (wr_data & edg_q) : '0;
    clr_m    = (wr_en && wr_off == OFF_CLR) ? (wr_data & edg_q) : '0;
    // a fresh edge outranks a clear on the same bit
    stat_nxt = (((stat_q & ~clr_m) | set_m | hit) & edg_q) | (lvl & ~edg_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      stat_q <= '0;
      en_q   <= '0;
      pol_q  <= '1;
      edg_q  <= '0;
    end else begin
      prev_q <= src_sync;
      stat_q <= stat_nxt;
      if (wr_en && wr_off == OFF_EN)   en_q  <= wr_data;
      if (wr_en && wr_off == OFF_POL)  pol_q <= wr_data;
      if (wr_en && wr_off == OFF_EDGE) edg_q <= wr_data;
    end
  end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int unsigned W     = 32,
  parameter int unsigned IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    idx = '0;
    any = |vec;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_BANKS   = 5,
  parameter int unsigned SRC_W       = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [ADDR_W-1:0]                    bus_addr,
  input  logic [SRC_W-1:0]                     bus_wdata,
  input  logic                                 bus_we,
  input  logic                                 bus_rd_en,
  output logic [SRC_W-1:0]                     bus_rdata,
  input  logic [NUM_BANKS*SRC_W-1:0]           irq_src,
  output logic [NUM_BANKS-1:0]                 irq_out,
  output logic [NUM_BANKS-1:0]                 irq_vld,
  output logic [NUM_BANKS*$clog2(SRC_W)-1:0]   irq_idx
);
  localparam int unsigned IDX_W  = $clog2(SRC_W);
  localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic              dec_hit;
  logic [BANK_W-1:0] dec_bank;
  logic [OFF_W-1:0]  dec_off;
  logic              dec_ok;

  logic [SRC_W-1:0] stat_arr [NUM_BANKS];
  logic [SRC_W-1:0] en_arr   [NUM_BANKS];
  logic [SRC_W-1:0] pol_arr  [NUM_BANKS];
  logic [SRC_W-1:0] edg_arr  [NUM_BANKS];
  logic [NUM_BANKS*SRC_W-1:0] pend_flat;
  logic [SRC_W-1:0] rd_val;

  always_comb begin
    dec_hit  = 1'b0;
    dec_bank = '0;
    dec_off  = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (int'(bus_addr) >= b * BANK_STRIDE &&
          int'(bus_addr) < (b + 1) * BANK_STRIDE) begin
        dec_hit  = 1'b1;
        dec_bank = BANK_W'(b);
        dec_off  = OFF_W'(int'(bus_addr) - b * BANK_STRIDE);
      end
    end
    dec_ok = dec_hit && off_legal(dec_off);
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [SRC_W-1:0] src_s;
    logic             wr_b;
    logic [IDX_W-1:0] idx_c;
    logic             any_c;

    assign wr_b = bus_we && dec_ok && (dec_bank == BANK_W'(b));

    irqc_sync #(.W(SRC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .din (irq_src[b*SRC_W +: SRC_W]),
      .dout(src_s)
    );

    irqc_bank #(.W(SRC_W)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .src_sync(src_s),
      .wr_en   (wr_b),
      .wr_off  (dec_off),
      .wr_data (bus_wdata),
      .stat_q  (stat_arr[b]),
      .en_q    (en_arr[b]),
      .pol_q   (pol_arr[b]),
      .edg_q   (edg_arr[b])
    );

    assign pend_flat[b*SRC_W +: SRC_W] = stat_arr[b] & en_arr[b];

    irqc_prio #(.W(SRC_W), .IDX_W(IDX_W)) u_prio (
      .vec(pend_flat[b*SRC_W +: SRC_W]),
      .idx(idx_c),
      .any(any_c)
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        irq_out[b]                  <= 1'b0;
        irq_vld[b]                  <= 1'b0;
        irq_idx[b*IDX_W +: IDX_W]   <= '0;
      end else begin
        irq_out[b]                  <= |pend_flat[b*SRC_W +: SRC_W];
        irq_vld[b]                  <= any_c;
        irq_idx[b*IDX_W +: IDX_W]   <= idx_c;
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (dec_ok) begin
      case (dec_off)
        OFF_STAT: rd_val = stat_arr[dec_bank];
        OFF_EN:   rd_val = en_arr[dec_bank];
        OFF_POL:  rd_val = pol_arr[dec_bank];
        OFF_EDGE: rd_val = edg_arr[dec_bank];
        default:  rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            bus_rdata <= '0;
    else if (bus_rd_en) bus_rdata <= rd_val;
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int unsigned NB     = 5,
  parameter int unsigned W      = 32,
  parameter int unsigned AW     = 8,
  parameter int unsigned STRIDE = 24
) (
  input logic                       clk,
  input logic                       rst,
  input logic [AW-1:0]              bus_addr,
  input logic                       bus_rd_en,
  input logic [W-1:0]               bus_rdata,
  input logic [NB-1:0]              irq_out,
  input logic [NB-1:0]              irq_vld,
  input logic [NB*$clog2(W)-1:0]    irq_idx,
  input logic [NB*W-1:0]            pend
);
  localparam int unsigned IW = $clog2(W);

  logic [NB*W-1:0] pend_d;
  always_ff @(posedge clk) begin
    if (rst) pend_d <= '0;
    else     pend_d <= pend;
  end

  p_reset_quiet_r2: assert property (@(posedge clk) $fell(rst) |-> irq_out == '0);

  p_wo_reads_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && int'(bus_addr) < NB * STRIDE &&
     ((int'(bus_addr) % STRIDE) == 8 || (int'(bus_addr) % STRIDE) == 12))
    |=> bus_rdata == '0);

  p_oor_read_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && int'(bus_addr) >= NB * STRIDE) |=> bus_rdata == '0);

  for (genvar b = 0; b < NB; b++) begin : g_chk
    p_line_valid_r7: assert property (@(posedge clk) disable iff (rst)
      irq_out[b] == irq_vld[b]);

    p_line_needs_req_r7: assert property (@(posedge clk) disable iff (rst)
      irq_out[b] |-> pend_d[b*W +: W] != '0);

    p_idx_lowest_r8: assert property (@(posedge clk) disable iff (rst)
      irq_vld[b] |->
        (pend_d[b*W + int'(irq_idx[b*IW +: IW])] &&
         ((pend_d[b*W +: W] & ((W'(1) << irq_idx[b*IW +: IW]) - W'(1))) == '0)));

    p_idx_zero_idle_r8: assert property (@(posedge clk) disable iff (rst)
      !irq_vld[b] |-> irq_idx[b*IW +: IW] == '0);
  end
endmodule

bind irq_bank_ctrl irqc_checker #(
  .NB(NUM_BANKS), .W(SRC_W), .AW(ADDR_W), .STRIDE(irqc_pkg::BANK_STRIDE)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_addr (bus_addr),
  .bus_rd_en(bus_rd_en),
  .bus_rdata(bus_rdata),
  .irq_out  (irq_out),
  .irq_vld  (irq_vld),
  .irq_idx  (irq_idx),
  .pend     (pend_flat)
);

// File: tb/irq_bank_ctrl_tb.sv
module irq_bank_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 5;
  localparam int W  = 32;
  localparam int AW = 8;
  localparam int IW = 5;

  localparam logic [4:0] O_STAT = 5'h00, O_EN = 5'h04, O_SET = 5'h08,
                         O_CLR = 5'h0C, O_POL = 5'h10, O_EDGE = 5'h14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic [W-1:0]  bus_wdata = '0;
  logic bus_we = 1'b0, bus_rd_en = 1'b0;
  logic [W-1:0] bus_rdata;
  logic [NB*W-1:0] irq_src = '0;
  logic [NB-1:0] irq_out, irq_vld;
  logic [NB*IW-1:0] irq_idx;

  int total = 0, bad = 0;
  bit done = 0;

  logic [W-1:0] m_en [NB], m_pol [NB], m_edg [NB], m_st [NB], m_in [NB];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_bank_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rd_en(bus_rd_en), .bus_rdata(bus_rdata),
    .irq_src(irq_src), .irq_out(irq_out), .irq_vld(irq_vld), .irq_idx(irq_idx)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] lowest(input logic [W-1:0] v);
    for (int i = 0; i < W; i++) if (v[i]) return 5'(i);
    return 5'd0;
  endfunction

  function automatic logic [W-1:0] lvl_of(input int b);
    return ~(m_in[b] ^ m_pol[b]);
  endfunction

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic wr(input int addr, input logic [W-1:0] d);
    @(negedge clk);
    bus_addr = AW'(addr); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int addr, output logic [W-1:0] d);
    @(negedge clk);
    bus_addr = AW'(addr); bus_rd_en = 1'b1;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic op_reg(input int b, input logic [4:0] off, input logic [W-1:0] d);
    wr(b * 24 + int'(off), d);
    case (off)
      O_EN:   m_en[b] = d;
      O_POL:  begin m_pol[b] = d; m_st[b] = (m_st[b] & m_edg[b]) | (lvl_of(b) & ~m_edg[b]); end
      O_EDGE: begin m_edg[b] = d; m_st[b] = (m_st[b] & m_edg[b]) | (lvl_of(b) & ~m_edg[b]); end
      O_SET:  m_st[b] = m_st[b] | (d & m_edg[b]);
      O_CLR:  m_st[b] = m_st[b] & ~(d & m_edg[b]);
      default: ;
    endcase
    settle();
  endtask

  task automatic op_in(input int b, input logic [W-1:0] v);
    logic [W-1:0] hits;
    @(negedge clk);
    hits = (m_pol[b] & ~m_in[b] & v) | (~m_pol[b] & m_in[b] & ~v);
    m_in[b] = v;
    irq_src[b*W +: W] = v;
    m_st[b] = ((m_st[b] | hits) & m_edg[b]) | (lvl_of(b) & ~m_edg[b]);
    settle();
  endtask

  task automatic check_bank(input int b, input string tag);
    logic [W-1:0] p, d;
    p = m_st[b] & m_en[b];
    chk($sformatf("%s R7 line b%0d", tag, b), 32'(irq_out[b]), 32'(|p));
    chk($sformatf("%s R8 vld b%0d", tag, b), 32'(irq_vld[b]), 32'(|p));
    chk($sformatf("%s R8 idx b%0d", tag, b), 32'(irq_idx[b*IW +: IW]), 32'(lowest(p)));
    rd(b * 24 + int'(O_STAT), d);
    chk($sformatf("%s status b%0d", tag, b), d, m_st[b]);
  endtask

  task automatic check_all(input string tag);
    for (int b = 0; b < NB; b++) check_bank(b, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] d;
    void'($urandom(32'd20240517));
    for (int b = 0; b < NB; b++) begin
      m_en[b] = '0; m_pol[b] = '1; m_edg[b] = '0; m_st[b] = '0; m_in[b] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R2 reset state
    chk("R2 lines", 32'(irq_out), 32'd0);
    chk("R2 idx", 32'(irq_idx[31:0]), 32'd0);
    rd(int'(O_POL), d);          chk("R2 pol b0", d, 32'hFFFF_FFFF);
    rd(4 * 24 + int'(O_EN), d);  chk("R2 en b4", d, 32'd0);
    rd(4 * 24 + int'(O_EDGE), d); chk("R2 edge b4", d, 32'd0);
    rd(int'(O_STAT), d);         chk("R2 stat b0", d, 32'd0);

    // R10 bring-up sequence
    for (int b = 0; b < NB; b++) begin
      op_reg(b, O_EN, '0);
      op_reg(b, O_CLR, '1);
      op_reg(b, O_POL, '1);
      op_reg(b, O_EDGE, (b == 0) ? 32'h0000_E000 : 32'h0);
    end
    check_all("R10 idle");
    op_in(0, 32'h0000_4000);
    op_in(0, 32'h0);
    op_reg(0, O_EN, 32'h0000_E000);
    chk("R10 latched idx", 32'(irq_idx[4:0]), 32'd14);
    check_bank(0, "R10 pulse");

    // R1 readback and write-only registers, R9 isolation
    op_reg(2, O_EN, 32'hA5A5_0F0F);
    rd(2 * 24 + int'(O_EN), d);   chk("R1 en readback", d, 32'hA5A5_0F0F);
    rd(2 * 24 + int'(O_SET), d);  chk("R1 set reads 0", d, 32'd0);
    rd(2 * 24 + int'(O_CLR), d);  chk("R1 clr reads 0", d, 32'd0);
    rd(8'h78, d);                 chk("R1 out of range", d, 32'd0);
    rd(1 * 24 + int'(O_EN), d);   chk("R9 bank1 en untouched", d, 32'd0);
    rd(3 * 24 + int'(O_EN), d);   chk("R9 bank3 en untouched", d, 32'd0);

    // R3 level active-low and active-high
    op_reg(1, O_EN, 32'h0000_0030);
    op_reg(1, O_POL, 32'hFFFF_FFEF);
    check_bank(1, "R3 low-active idle");
    op_in(1, 32'h0000_0030);
    check_bank(1, "R3 low-active driven");
    op_in(1, 32'h0);

    // R4 edge rise and fall latching
    op_reg(3, O_EDGE, 32'h0000_0003);
    op_reg(3, O_POL,  32'hFFFF_FFFE);
    op_reg(3, O_EN,   32'h0000_0003);
    op_in(3, 32'h0000_0003);
    chk("R4 rise only bit1", m_st[3], 32'h2);
    check_bank(3, "R4 rise");
    op_in(3, 32'h0);
    check_bank(3, "R4 fall held");

    // R6 set on level bits ignored, set on edge bits works
    op_reg(3, O_CLR, '1);
    op_reg(3, O_SET, 32'h0000_0104);
    chk("R6 level bit unchanged", m_st[3], 32'h0);
    check_bank(3, "R6 set");
    op_reg(0, O_SET, 32'h0000_8000);
    check_bank(0, "R6 edge set");

    // R5 clear and same-cycle edge wins on bank 0 bit 13
    op_reg(0, O_CLR, '1);
    check_bank(0, "R5 cleared");
    @(negedge clk);
    irq_src[13] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_addr = AW'(int'(O_CLR)); bus_wdata = 32'h0000_2000; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    m_in[0][13] = 1'b1; m_st[0][13] = 1'b1;
    settle();
    check_bank(0, "R5 edge beats clear");

    // random mix
    for (int it = 0; it < 300; it++) begin
      int b, k;
      logic [W-1:0] v;
      b = $urandom_range(0, NB - 1);
      k = $urandom_range(0, 7);
      v = $urandom;
      case (k)
        0, 1, 2: op_in(b, v);
        3: op_reg(b, O_EN, v);
        4: op_reg(b, O_POL, v);
        5: op_reg(b, O_EDGE, v);
        6: op_reg(b, O_SET, v);
        default: op_reg(b, O_CLR, v);
      endcase
      check_bank(b, "rand R3 R4 R7");
      if (it % 50 == 0) check_all("rand R9");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule